// File: doc/BRIEF.md
# IOMMU Global Bypass Control

This block holds one 32-bit memory-mapped control word for an I/O memory-management unit. The word sets how device traffic is handled while address translation is switched off. Software updates the word through a simple register port. A write only lands when it carries a commit flag in its top bit. The register keeps the rest of the written word, with the commit flag cleared.

A second port takes transaction requests, one per cycle. For each request, the block returns a routing verdict one cycle later:

- When translation is on, every request is sent to the translation path.
- When translation is off, a single halt flag in the stored word decides the verdict. A set flag aborts the request. A clear flag lets it pass through untranslated.

Reset loads a value whose halt flag is clear, so untranslated traffic passes through by default.

Top module: `iommu_bypass_ctl`

## Requirements
- R1: After reset the stored word is 0x0000_1000, a read at the register offset returns that value, and no verdict strobe is raised until a request arrives.
- R2: Only accesses whose byte address equals the register offset (default 0x44) can change the stored word. A write to any other address, even one with bit 31 set, leaves the word unchanged.
- R3: A write at the register offset with bit 31 (the commit flag) clear is ignored entirely, and the stored word stays as it was.
- R4: A write at the register offset with bit 31 set stores the written data with bit 31 forced to 0, so bit 31 of the stored word always reads back as 0.
- R5: A read strobe at the register offset returns the stored word on the read data port one cycle later, with the read-valid output high in that cycle. A read issued in the same cycle as a committing write returns the value held before the write.
- R6: A read strobe at any other address returns zero one cycle later, with read-valid high.
- R7: While the translation-enable input is high, every request is answered with route code 0 (translate), whatever the stored word holds.
- R8: While translation is disabled and bit 20 (the halt flag) of the stored word is 1, every request is answered with route code 2 (abort).
- R9: While translation is disabled and bit 20 of the stored word is 0, every request is answered with route code 1 (bypass).
- R10: The verdict valid strobe is high exactly in the cycle after a request, and it is low after any cycle without a request.
- R11: A request in the same cycle as a committing write is decided using the stored word from before that write. The next request sees the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| reg_rvalid | output | 1 | High when reg_rdata carries a read result |
| xlate_on | input | 1 | Translation engine enabled |
| txn_req | input | 1 | Transaction request strobe |
| txn_resp_valid | output | 1 | Verdict strobe, one cycle after a request |
| txn_resp_route | output | 2 | Verdict: 0 translate, 1 bypass, 2 abort |

## Verification
The bench alternates committing and non-committing writes with the same payload. A design that skips the commit test would show a changed readback where none is expected. It also writes words with every bit but the commit flag set, to catch a design that stores bit 31 or drops bits near the halt flag. Writes at neighbouring addresses with the commit flag set catch loose address decoding. A write and a request placed in the same cycle expose a design that forwards the new halt flag too early. A reset in mid-run catches a wrong reset value.

// File: rtl/iommu_bypass_ctl_pkg.sv
package iommu_bypass_ctl_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned HALT_BIT   = 20;
    localparam int unsigned COMMIT_BIT = 31;
    localparam logic [WORD_W-1:0] WORD_RESET = 32'h0000_1000;

    typedef enum logic [1:0] {
        ROUTE_TRANSLATE = 2'd0,
        ROUTE_BYPASS    = 2'd1,
        ROUTE_ABORT     = 2'd2
    } route_e;

    typedef struct packed {
        logic   valid;
        route_e route;
    } verdict_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } rd_resp_t;

    function automatic logic carries_commit(input logic [WORD_W-1:0] w);
        return w[COMMIT_BIT];
    endfunction

    function automatic logic [WORD_W-1:0] strip_commit(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        r[COMMIT_BIT] = 1'b0;
        return r;
    endfunction

    function automatic route_e pick_route(input logic xlate, input logic halt);
        if (xlate)     return ROUTE_TRANSLATE;
        else if (halt) return ROUTE_ABORT;
        else           return ROUTE_BYPASS;
    endfunction

endpackage

// File: rtl/iommu_bypass_ctl_decode.sv
module iommu_bypass_ctl_decode #(
    parameter int unsigned ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h044
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic match;

    always_comb begin
        match  = (addr == REG_OFFSET);
        wr_hit = wr_en & match;
        rd_hit = rd_en & match;
    end
endmodule

// File: rtl/iommu_bypass_ctl_store.sv
module iommu_bypass_ctl_store
    import iommu_bypass_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word_q
);
    logic              take;
    logic [WORD_W-1:0] word_d;

    always_comb begin
        take   = wr_hit & carries_commit(wdata);
        word_d = take ? strip_commit(wdata) : word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= WORD_RESET;
        else     word_q <= word_d;
    end
endmodule

// File: rtl/iommu_bypass_ctl_readback.sv
module iommu_bypass_ctl_readback
    import iommu_bypass_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rd_hit,
    input  logic [WORD_W-1:0] word_q,
    output rd_resp_t          resp_q
);
    rd_resp_t resp_d;

    always_comb begin
        resp_d.valid = rd_en;
        resp_d.data  = rd_hit ? word_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) resp_q <= '0;
        else     resp_q <= resp_d;
    end
endmodule

// File: rtl/iommu_bypass_ctl_decide.sv
module iommu_bypass_ctl_decide
    import iommu_bypass_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  logic     xlate_on,
    input  logic     halt,
    output verdict_t verdict_q
);
    verdict_t verdict_d;

    always_comb begin
        verdict_d.valid = req;
        verdict_d.route = req ? pick_route(xlate_on, halt) : ROUTE_TRANSLATE;
    end

    always_ff @(posedge clk) begin
        if (rst) verdict_q <= '{valid: 1'b0, route: ROUTE_TRANSLATE};
        else     verdict_q <= verdict_d;
    end
endmodule

// File: rtl/iommu_bypass_ctl.sv
module iommu_bypass_ctl
    import iommu_bypass_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h044
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    input  logic              xlate_on,
    input  logic              txn_req,
    output logic              txn_resp_valid,
    output logic [1:0]        txn_resp_route
);
    logic              wr_hit;
    logic              rd_hit;
    logic [WORD_W-1:0] cfg_q;
    rd_resp_t          rd_resp;
    verdict_t          verdict;

    iommu_bypass_ctl_decode #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_decode (
        .addr   (reg_addr),
        .wr_en  (reg_wr_en),
        .rd_en  (reg_rd_en),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    iommu_bypass_ctl_store u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wdata  (reg_wdata),
        .word_q (cfg_q)
    );

    iommu_bypass_ctl_readback u_readback (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (reg_rd_en),
        .rd_hit (rd_hit),
        .word_q (cfg_q),
        .resp_q (rd_resp)
    );

    iommu_bypass_ctl_decide u_decide (
        .clk       (clk),
        .rst       (rst),
        .req       (txn_req),
        .xlate_on  (xlate_on),
        .halt      (cfg_q[HALT_BIT]),
        .verdict_q (verdict)
    );

    assign reg_rdata      = rd_resp.data;
    assign reg_rvalid     = rd_resp.valid;
    assign txn_resp_valid = verdict.valid;
    assign txn_resp_route = verdict.route;
endmodule

// File: rtl/iommu_bypass_ctl_chk.sv
module iommu_bypass_ctl_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h044
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              reg_rvalid,
    input logic              xlate_on,
    input logic              txn_req,
    input logic              txn_resp_valid,
    input logic [1:0]        txn_resp_route,
    input logic [31:0]       cfg_q
);
    // R2
    off_addr_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr != REG_OFFSET) |=> $stable(cfg_q));

    // R3
    no_commit_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == REG_OFFSET && !reg_wdata[31]) |=> $stable(cfg_q));

    // R4
    commit_store_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == REG_OFFSET && reg_wdata[31])
        |=> (cfg_q == {1'b0, $past(reg_wdata[30:0])}));

    // R4
    commit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rvalid |-> !reg_rdata[31]);

    // R6
    off_addr_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr != REG_OFFSET) |=> (reg_rvalid && reg_rdata == 32'd0));

    // R7
    xlate_route_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_req && xlate_on) |=> (txn_resp_route == 2'd0));

    // R8
    abort_route_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_req && !xlate_on && cfg_q[20]) |=> (txn_resp_route == 2'd2));

    // R9
    bypass_route_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_req && !xlate_on && !cfg_q[20]) |=> (txn_resp_route == 2'd1));

    // R10
    resp_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        txn_req |=> txn_resp_valid);

    // R10
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !txn_req |=> !txn_resp_valid);
endmodule

bind iommu_bypass_ctl iommu_bypass_ctl_chk #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_wr_en      (reg_wr_en),
    .reg_rd_en      (reg_rd_en),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .reg_rvalid     (reg_rvalid),
    .xlate_on       (xlate_on),
    .txn_req        (txn_req),
    .txn_resp_valid (txn_resp_valid),
    .txn_resp_route (txn_resp_route),
    .cfg_q          (cfg_q)
);

// File: tb/iommu_bypass_ctl_tb.sv
module iommu_bypass_ctl_tb;
    localparam int unsigned ADDR_W = 12;
    localparam logic [ADDR_W-1:0] OFF = 12'h044;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr_en = 1'b0;
    logic              reg_rd_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              reg_rvalid;
    logic              xlate_on = 1'b0;
    logic              txn_req = 1'b0;
    logic              txn_resp_valid;
    logic [1:0]        txn_resp_route;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    iommu_bypass_ctl #(.ADDR_W(ADDR_W), .REG_OFFSET(OFF)) u_dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .xlate_on(xlate_on), .txn_req(txn_req),
        .txn_resp_valid(txn_resp_valid), .txn_resp_route(txn_resp_route)
    );

    // Vector: addr[78:67] wdata[66:35] xlate[34] exp_word[33:2] exp_route[1:0]
    localparam int NV = 8;
    localparam logic [78:0] VEC [NV] = '{
        {12'h044, 32'h8010_0000, 1'b0, 32'h0010_0000, 2'd2},
        {12'h044, 32'h0000_0000, 1'b0, 32'h0010_0000, 2'd2},
        {12'h044, 32'h8000_0000, 1'b0, 32'h0000_0000, 2'd1},
        {12'h040, 32'h8010_0000, 1'b0, 32'h0000_0000, 2'd1},
        {12'h044, 32'h80FF_FFFF, 1'b1, 32'h00FF_FFFF, 2'd0},
        {12'h044, 32'h7FFF_FFFF, 1'b0, 32'h00FF_FFFF, 2'd2},
        {12'h044, 32'hFFEF_FFFF, 1'b0, 32'h7FEF_FFFF, 2'd1},
        {12'h048, 32'h8010_0000, 1'b1, 32'h7FEF_FFFF, 2'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d, input logic req, input logic xl);
        reg_wr_en = wr; reg_rd_en = rd; reg_addr = a; reg_wdata = d;
        txn_req = req; xlate_on = xl;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_rd_en = 1'b0; txn_req = 1'b0;
    endtask

    task automatic read_word(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        step(1'b0, 1'b1, a, 32'd0, 1'b0, 1'b0);
        check({tag, " rvalid"}, {31'd0, reg_rvalid}, 32'd1);
        check({tag, " rdata"}, reg_rdata, exp);
    endtask

    task automatic request(input string tag, input logic xl, input logic [1:0] exp);
        step(1'b0, 1'b0, OFF, 32'd0, 1'b1, xl);
        check({tag, " valid"}, {31'd0, txn_resp_valid}, 32'd1);
        check({tag, " route"}, {30'd0, txn_resp_route}, {30'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 resp_valid after reset", {31'd0, txn_resp_valid}, 32'd0);
        check("R1 rvalid after reset", {31'd0, reg_rvalid}, 32'd0);
        read_word("R1 reset word", OFF, 32'h0000_1000);
        request("R9 reset bypass", 1'b0, 2'd1);

        // Table walk: R2 R3 R4 R5 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            step(1'b1, 1'b0, VEC[i][78:67], VEC[i][66:35], 1'b0, 1'b0);
            read_word($sformatf("R2/R3/R4/R5 vec%0d", i), OFF, VEC[i][33:2]);
            request($sformatf("R7/R8/R9 vec%0d", i), VEC[i][34], VEC[i][1:0]);
        end

        // R6: other offsets read zero
        read_word("R6 read 0x040", 12'h040, 32'd0);
        read_word("R6 read 0x045", 12'h045, 32'd0);

        // R10: no request, no strobe
        step(1'b0, 1'b0, OFF, 32'd0, 1'b0, 1'b0);
        check("R10 idle no strobe", {31'd0, txn_resp_valid}, 32'd0);

        // R11: request with committing write in same cycle uses old word (halt=0)
        step(1'b1, 1'b0, OFF, 32'h8010_0000, 1'b1, 1'b0);
        check("R11 same-cycle route", {30'd0, txn_resp_route}, 32'd1);
        check("R11 same-cycle valid", {31'd0, txn_resp_valid}, 32'd1);
        request("R11 next request", 1'b0, 2'd2);

        // R5: read together with committing write returns old value
        step(1'b1, 1'b1, OFF, 32'h8000_0123, 1'b0, 1'b0);
        check("R5 read-during-write old", reg_rdata, 32'h0010_0000);
        read_word("R5 read after write", OFF, 32'h0000_0123);

        // R8 again with translation toggled back on: R7
        request("R7 xlate ignores word", 1'b1, 2'd0);

        // R1: mid-run reset restores word
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_word("R1 word after second reset", OFF, 32'h0000_1000);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule